// File: doc/BRIEF.md
# Intermediate Port Selector for a Distributed Shared Memory Switch

In a switch where every line card also lends its local buffer to the fabric, each arriving cell is stored on some intermediate card. The cell later leaves from that card toward its output. This block chooses that intermediate card. Each card's buffer can accept only `S1` writes per time slot and can give up only `S2` reads per slot. A card is therefore a valid choice only if both of these hold:

- it still has a spare write opportunity in the slot the cell arrives in;
- it still has a spare read opportunity in the slot the cell is due to depart in.

The block keeps occupancy counters for both resources. Write counters cover the running slot. A circular table, `DEPTH` rows deep, holds read reservations for upcoming slots. Requests arrive one per clock, in input order. Each request gives the distance in slots to its departure slot. The block answers one clock later with the chosen card, or with a refusal flag, and it books both resources on the chosen card. An end-of-slot strobe closes the running slot. It clears the write counters and the table row of the slot that just finished, and moves the slot pointer forward.

As long as no more than `N` cells arrive in a slot, no more than `N` cells are due in any one slot, and floor((N-1)/S1) + floor((N-1)/S2) < N holds, a free card always exists. Under those conditions the refusal flag should never rise.

Top module: `xport_selector`

## Requirements
- R1: After reset `gnt_valid`, `gnt_none` and `gnt_port` are 0. All counters are empty, so the first request with a nonzero delay is granted card 0.
- R2: The answer to a request sampled at a rising edge appears on the outputs after that edge and stays there for one clock. `gnt_valid` and `gnt_none` are never both high. `gnt_port` is 0 whenever `gnt_valid` is low. A cycle with no request yields `gnt_valid`=0 and `gnt_none`=0.
- R3: Within one slot, no card is granted more than `S1` times.
- R4: Over all slots, no card holds more than `S2` reservations for any one departure slot.
- R5: Among the eligible cards, the one with the lowest index is granted.
- R6: When no card is eligible, `gnt_none` is 1 for one clock and nothing is booked. An identical request that follows sees the same state.
- R7: The departure slot is the current slot plus `req_delay`, taken modulo `DEPTH`, with `req_delay` in 1..DEPTH-1. A `req_delay` of 0 is refused through `gnt_none` and books nothing.
- R8: A request that arrives together with `slot_end` belongs to the slot that is ending. At `slot_end` the write counters reset and the table row of the ending slot is emptied, so that row can be reused after `DEPTH` slots.
- R9: With at most `N` arrivals per slot, at most `N` departures per slot, and the speedup condition met (defaults N=4, S1=S2=2), `gnt_none` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_end | input | 1 | Strobe marking the last clock of the current slot |
| req_valid | input | 1 | A cell needs an intermediate card this clock |
| req_delay | input | $clog2(DEPTH) | Slots from now until the cell departs |
| gnt_valid | output | 1 | A card was chosen for the previous request |
| gnt_port | output | $clog2(N) | Index of the chosen card |
| gnt_none | output | 1 | The previous request was refused |

## Verification
A write counter that is off by one shows up at the ports quickly. Within the same slot it produces a grant to a card that should already be full, or a refusal where a card was still free. The mismatch appears in the same clock as the first grant that differs from the model. A stale or misplaced read reservation stays hidden until a later cell targets that departure slot. That can be as many as `DEPTH`-1 slots later, so the bench runs traffic through several full turns of the table. A slot pointer that advances wrongly moves every later reservation to a different row. The first refusal or grant that differs from the model then reveals it.

// File: rtl/xps_pkg.sv
package xps_pkg;

  // Circular add used for the slot pointer and the departure row.
  function automatic int unsigned wrap_add(input int unsigned base,
                                           input int unsigned off,
                                           input int unsigned depth);
    int unsigned s;
    s = base + off;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

  // Bits needed to hold a count from 0 up to maxval.
  function automatic int unsigned ctr_bits(input int unsigned maxval);
    return (maxval < 1) ? 1 : $clog2(maxval + 1);
  endfunction

endpackage

// File: rtl/xps_wr_counters.sv
module xps_wr_counters #(
  parameter int N   = 4,
  parameter int S1  = 2,
  parameter int WCW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [N-1:0]     inc_oh,
  output logic [N-1:0]     room,
  output logic [N*WCW-1:0] cnt_flat
);
  localparam logic [WCW-1:0] WMAX = WCW'(S1);

  logic [WCW-1:0] cnt [N];

  // Clearing wins: a request seen together with the boundary belongs to the ending slot.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < N; p++) cnt[p] <= '0;
    end else begin
      for (int p = 0; p < N; p++) begin
        if (clr) cnt[p] <= '0;
        else if (inc_oh[p] && cnt[p] < WMAX) cnt[p] <= cnt[p] + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_port
    assign room[g] = cnt[g] < WMAX;
    assign cnt_flat[g*WCW +: WCW] = cnt[g];
  end

endmodule

// File: rtl/xps_rd_table.sv
module xps_rd_table #(
  parameter int N     = 4,
  parameter int DEPTH = 8,
  parameter int S2    = 2,
  parameter int RCW   = 2,
  parameter int PTRW  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr_en,
  input  logic [PTRW-1:0]        clr_row,
  input  logic [PTRW-1:0]        inc_row,
  input  logic [N-1:0]           inc_oh,
  input  logic [PTRW-1:0]        look_row,
  output logic [N-1:0]           room,
  output logic [DEPTH*N*RCW-1:0] cnt_flat
);
  localparam logic [RCW-1:0] RMAX = RCW'(S2);

  logic [RCW-1:0] tab [DEPTH][N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < DEPTH; r++)
        for (int p = 0; p < N; p++) tab[r][p] <= '0;
    end else begin
      for (int r = 0; r < DEPTH; r++) begin
        for (int p = 0; p < N; p++) begin
          if (clr_en && clr_row == PTRW'(r))
            tab[r][p] <= '0;
          else if (inc_oh[p] && inc_row == PTRW'(r) && tab[r][p] < RMAX)
            tab[r][p] <= tab[r][p] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int p = 0; p < N; p++) room[p] = tab[look_row][p] < RMAX;
  end

  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    for (genvar p = 0; p < N; p++) begin : g_col
      assign cnt_flat[(r*N+p)*RCW +: RCW] = tab[r][p];
    end
  end

endmodule

// File: rtl/xps_lowest_pick.sv
module xps_lowest_pick #(
  parameter int N  = 4,
  parameter int PW = 2
) (
  input  logic [N-1:0]  vec,
  output logic [N-1:0]  oh,
  output logic [PW-1:0] idx,
  output logic          any
);
  // Scan from the top so the lowest set bit is the last one written.
  always_comb begin
    oh  = '0;
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        oh    = '0;
        oh[i] = 1'b1;
        idx   = PW'(i);
        any   = 1'b1;
      end
    end
  end

endmodule

// File: rtl/xport_selector.sv
module xport_selector
  import xps_pkg::*;
#(
  parameter int N     = 4,
  parameter int S1    = 2,
  parameter int S2    = 2,
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     slot_end,
  input  logic                     req_valid,
  input  logic [$clog2(DEPTH)-1:0] req_delay,
  output logic                     gnt_valid,
  output logic [$clog2(N)-1:0]     gnt_port,
  output logic                     gnt_none
);
  localparam int PW   = $clog2(N);
  localparam int PTRW = $clog2(DEPTH);
  localparam int WCW  = ctr_bits(S1);
  localparam int RCW  = ctr_bits(S2);

  logic [PTRW-1:0]        cur_slot;
  logic [PTRW-1:0]        look_row;
  logic [N-1:0]           wr_room, rd_room, elig_vec, pick_oh, inc_oh;
  logic [PW-1:0]          pick_idx;
  logic                   pick_any, dly_ok, take_fire, fail_fire;
  logic [N*WCW-1:0]       wr_flat;
  logic [DEPTH*N*RCW-1:0] rd_flat;

  assign dly_ok    = req_delay != '0;
  assign look_row  = PTRW'(wrap_add(32'(cur_slot), 32'(req_delay), DEPTH));
  assign elig_vec  = wr_room & rd_room;
  assign take_fire = req_valid && dly_ok && pick_any;
  assign fail_fire = req_valid && !take_fire;
  assign inc_oh    = take_fire ? pick_oh : '0;

  xps_wr_counters #(.N(N), .S1(S1), .WCW(WCW)) wr_i (
    .clk(clk), .rst_n(rst_n), .clr(slot_end), .inc_oh(inc_oh),
    .room(wr_room), .cnt_flat(wr_flat)
  );

  xps_rd_table #(.N(N), .DEPTH(DEPTH), .S2(S2), .RCW(RCW), .PTRW(PTRW)) rd_i (
    .clk(clk), .rst_n(rst_n), .clr_en(slot_end), .clr_row(cur_slot),
    .inc_row(look_row), .inc_oh(inc_oh), .look_row(look_row),
    .room(rd_room), .cnt_flat(rd_flat)
  );

  xps_lowest_pick #(.N(N), .PW(PW)) pick_i (
    .vec(elig_vec), .oh(pick_oh), .idx(pick_idx), .any(pick_any)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_slot  <= '0;
      gnt_valid <= 1'b0;
      gnt_none  <= 1'b0;
      gnt_port  <= '0;
    end else begin
      if (slot_end) cur_slot <= PTRW'(wrap_add(32'(cur_slot), 1, DEPTH));
      gnt_valid <= take_fire;
      gnt_none  <= fail_fire;
      gnt_port  <= take_fire ? pick_idx : '0;
    end
  end

endmodule

// File: rtl/xport_selector_chk.sv
module xport_selector_chk #(
  parameter int N     = 4,
  parameter int S1    = 2,
  parameter int S2    = 2,
  parameter int DEPTH = 8,
  parameter int WCW   = 2,
  parameter int RCW   = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     slot_end,
  input logic                     req_valid,
  input logic [$clog2(DEPTH)-1:0] req_delay,
  input logic                     gnt_valid,
  input logic                     gnt_none,
  input logic [N-1:0]             elig_vec,
  input logic [N-1:0]             inc_oh,
  input logic                     take_fire,
  input logic                     fail_fire,
  input logic [N*WCW-1:0]         wr_flat,
  input logic [DEPTH*N*RCW-1:0]   rd_flat
);

  for (genvar p = 0; p < N; p++) begin : g_wcap
    AST_WR_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      wr_flat[p*WCW +: WCW] <= WCW'(S1)); // R3
  end

  for (genvar e = 0; e < DEPTH*N; e++) begin : g_rcap
    AST_RD_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      rd_flat[e*RCW +: RCW] <= RCW'(S2)); // R4
  end

  AST_ONE_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(inc_oh)); // R5
  AST_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    take_fire |-> ((elig_vec & (inc_oh - 1'b1)) == '0)); // R5
  AST_FAIL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_fire && req_delay != '0) |-> (elig_vec == '0)); // R6
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(gnt_valid && gnt_none)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!gnt_valid && !gnt_none)); // R2
  AST_ZERO_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_delay == '0) |=> gnt_none); // R7
  AST_TICK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> (wr_flat == '0)); // R8

endmodule

bind xport_selector xport_selector_chk #(
  .N(N), .S1(S1), .S2(S2), .DEPTH(DEPTH), .WCW(WCW), .RCW(RCW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .slot_end(slot_end), .req_valid(req_valid),
  .req_delay(req_delay), .gnt_valid(gnt_valid), .gnt_none(gnt_none),
  .elig_vec(elig_vec), .inc_oh(inc_oh), .take_fire(take_fire),
  .fail_fire(fail_fire), .wr_flat(wr_flat), .rd_flat(rd_flat)
);

// File: tb/xport_selector_tb_top.sv
`timescale 1ns/1ps
module xport_selector_tb_top;
  localparam int N = 4, S1 = 2, S2 = 2, DEPTH = 8;
  localparam int PW = $clog2(N), DW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0, slot_end = 1'b0, req_valid = 1'b0;
  logic [DW-1:0] req_delay = '0;
  logic gnt_valid, gnt_none;
  logic [PW-1:0] gnt_port;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  // Reference state
  int wr [N];
  int rd [DEPTH][N];
  int cur = 0;
  int abs_slot = 0;
  int load [int];
  int last_none = 0;

  always #10 clk = ~clk;

  xport_selector #(.N(N), .S1(S1), .S2(S2), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .slot_end(slot_end), .req_valid(req_valid),
    .req_delay(req_delay), .gnt_valid(gnt_valid), .gnt_port(gnt_port),
    .gnt_none(gnt_none)
  );

  task automatic step(input bit v, input int d, input bit tick, input string tag);
    int ev = 0, en = 0, ep = 0;
    if (v) begin
      if (d == 0) en = 1;
      else begin
        int row = (cur + d) % DEPTH;
        for (int p = 0; p < N; p++) begin
          if (ev == 0 && wr[p] < S1 && rd[row][p] < S2) begin
            ev = 1; ep = p; wr[p]++; rd[row][p]++;
          end
        end
        if (ev == 0) en = 1;
      end
    end
    if (tick) begin
      for (int p = 0; p < N; p++) begin wr[p] = 0; rd[cur][p] = 0; end
      cur = (cur + 1) % DEPTH;
      abs_slot++;
    end
    last_none = en;
    req_valid = v; req_delay = DW'(d); slot_end = tick;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; slot_end = 1'b0;
    vectors++;
    if (gnt_valid !== ev[0] || gnt_none !== en[0] || int'(gnt_port) != ep) begin
      miscompares++;
      $display("FAIL %s: got v=%0b none=%0b port=%0d, expected v=%0b none=%0b port=%0d",
               tag, gnt_valid, gnt_none, gnt_port, ev, en, ep);
    end
  endtask

  initial begin
    for (int p = 0; p < N; p++) begin
      wr[p] = 0;
      for (int r = 0; r < DEPTH; r++) rd[r][p] = 0;
    end
    repeat (3) @(negedge clk);
    vectors++;
    if (gnt_valid !== 1'b0 || gnt_none !== 1'b0 || gnt_port !== '0) begin
      miscompares++;
      $display("FAIL R1 reset: got v=%0b none=%0b port=%0d, expected 0 0 0",
               gnt_valid, gnt_none, gnt_port);
    end
    rst_n = 1'b1;
    step(0, 0, 0, "R2 idle after reset");
    step(1, 3, 0, "R1 first grant card 0");
    step(1, 3, 0, "R5 card 0 second write");
    step(1, 3, 0, "R5 card 0 full, card 1");
    // Fill the remaining write slots of this slot (R3)
    step(1, 1, 0, "R3 fill");
    step(1, 2, 0, "R3 fill");
    step(1, 4, 0, "R3 fill");
    step(1, 5, 0, "R3 fill");
    step(1, 6, 0, "R3 last write slot");
    step(1, 1, 0, "R3 write cap refusal");
    step(1, 1, 0, "R6 repeated refusal, state unchanged");
    step(0, 0, 0, "R2 idle");
    step(0, 0, 1, "R8 slot end clears writes");
    step(1, 1, 0, "R8 card 0 writable again");
    // Read cap: nine cells aimed at one departure slot across two slots (R4)
    step(0, 0, 1, "R8 boundary");
    for (int k = 0; k < 5; k++) step(1, 6, 0, "R4 reserve");
    step(0, 0, 1, "R8 boundary");
    for (int k = 0; k < 3; k++) step(1, 5, 0, "R4 reserve");
    step(1, 5, 0, "R4 read cap refusal");
    step(1, 0, 0, "R7 zero delay refused");
    step(1, 7, 1, "R8 request with slot end, longest delay");
    // Drain every row
    for (int k = 0; k < DEPTH + 1; k++) step(0, 0, 1, "R8 drain");
    // Bounded traffic: at most N arrivals and N departures per slot (R9)
    for (int s = 0; s < 4 * DEPTH; s++) begin
      for (int a = 0; a < N; a++) begin
        int d;
        d = 1 + int'($urandom_range(DEPTH - 2, 0));
        while (load.exists(abs_slot + d) && load[abs_slot + d] >= N)
          d = (d % (DEPTH - 1)) + 1;
        if (load.exists(abs_slot + d)) load[abs_slot + d]++;
        else load[abs_slot + d] = 1;
        step(1, d, a == N - 1, "R9 bounded traffic");
        vectors++;
        if (last_none != 0 || gnt_none !== 1'b0) begin
          miscompares++;
          $display("FAIL R9: got none=%0b, expected none=0", gnt_none);
        end
      end
    end
    step(0, 0, 0, "R2 final idle");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule